// File: doc/BRIEF.md
# Checkpointed Register File with Invalid-Bit Tracking

This block is the architectural register file of a core that keeps pre-executing instructions while a cache miss is outstanding. Every register carries a data word, a flag saying whether that word is trustworthy (the invalid flag) and a shadow copy. On entry to the speculative mode, one pulse snapshots all registers into their shadows in a single clock. On exit, one pulse puts every shadow back and marks every register valid again, which throws away everything computed speculatively.

Two combinational read ports return a data word and its invalid flag. One write port takes the result of a register-to-register operation or a load, together with the side information needed to judge it: the invalid flags the instruction saw on its sources and, for loads, a cache-miss bit and a poisoned-word bit. The block works out the flag that is stored with the data. Decode and the data cache stay outside the block.

The block holds no stream. Writes, checkpoint and restore are plain control pins that take effect at the next rising edge. They have no handshake and cannot be refused, so there is no back-pressure to manage.

Top module: `rah_ckpt_regfile`

## Requirements
- R1: After reset every register reads data 0 with its invalid flag clear, on both read ports.
- R2: Each read port returns, without a clock of delay, the stored data and invalid flag of the register it addresses. A write is stored at the rising edge where wr_en is high.
- R3: When a read port addresses the register being written in the same cycle, it returns the incoming data and the incoming flag (write-first bypass).
- R4: Register 0 always reads 0 with its flag clear. Writes to it are dropped.
- R5: In speculative mode (spec_mode=1), a register-to-register write (wr_kind=0) stores its data and sets the flag if either bit of wr_src_inv is 1.
- R6: In speculative mode, a register-to-register write with wr_src_inv=00 stores its data and clears a flag that was previously set.
- R7: In speculative mode, a load write (wr_kind=1) sets the flag if its base register was invalid (wr_src_inv bit 0), if wr_ld_miss is 1, or if wr_ld_word_inv is 1.
- R8: In speculative mode, a load with none of those three conditions stores its data and clears the flag.
- R9: Outside speculative mode, every write stores its data with the flag clear, whatever the inputs wr_src_inv, wr_ld_miss and wr_ld_word_inv say.
- R10: A checkpoint pulse copies every register's data into its shadow in one edge. A write in the same cycle is stored in the register, while the shadow receives the value from before that write.
- R11: A restore pulse reloads every register from its shadow in one edge and clears every invalid flag. A write in the same cycle is discarded and is not bypassed to the read ports.
- R12: Checkpoint and restore in the same cycle exchange the two copies: the registers take the old shadows and the shadows take the old register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| spec_mode | input | 1 | High while pre-executing under a miss |
| ckpt_req | input | 1 | Snapshot all registers into their shadows |
| rstr_req | input | 1 | Reload registers from shadows, clear all flags |
| rd_addr_a | input | AW | Read port A address |
| rd_data_a | output | DW | Read port A data |
| rd_inv_a | output | 1 | Read port A invalid flag |
| rd_addr_b | input | AW | Read port B address |
| rd_data_b | output | DW | Read port B data |
| rd_inv_b | output | 1 | Read port B invalid flag |
| wr_en | input | 1 | Write enable |
| wr_kind | input | 1 | 0 register-to-register result, 1 load result |
| wr_addr | input | AW | Destination register |
| wr_data | input | DW | Result data |
| wr_src_inv | input | 2 | Source invalid flags seen by the writer; bit 0 is the load base |
| wr_ld_miss | input | 1 | Load missed in the cache |
| wr_ld_word_inv | input | 1 | Load hit a word poisoned by an earlier store |

## Verification
The collisions that matter are a write landing in the same cycle as a checkpoint, as a restore, or as a read of the same register. Checkpoint and restore can also fall together. The bench provokes each of these in directed cycles and then in a long random run in which all of them fire freely. A behavioural model of registers, shadows and flags predicts both read ports on every clock. The model judges a collision by what the read ports show, both in the cycle of the collision and in the cycles after it: a write that lands with a restore must never be visible, and a shadow must hold the value from before the write it met.

// File: rtl/rah_rf_pkg.sv
package rah_rf_pkg;
  typedef enum logic {
    WK_ALU  = 1'b0,
    WK_LOAD = 1'b1
  } wr_kind_e;
endpackage

// File: rtl/rah_inv_eval.sv
// Works out the invalid flag stored with a write.
module rah_inv_eval
  import rah_rf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       spec_mode,
  input  logic       kind,
  input  logic [1:0] src_inv,
  input  logic       ld_miss,
  input  logic       ld_word_inv,
  output logic       wr_inv
);
  wr_kind_e kind_e;
  logic     raw_inv;

  always_comb begin
    kind_e = wr_kind_e'(kind);
    unique case (kind_e)
      WK_ALU:  raw_inv = src_inv[0] | src_inv[1];
      WK_LOAD: raw_inv = src_inv[0] | ld_miss | ld_word_inv;
      default: raw_inv = 1'b0;
    endcase
    wr_inv = spec_mode & raw_inv;
  end

  assert_quiet_outside_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !spec_mode |-> !wr_inv);
  assert_load_miss_poisons_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (spec_mode && kind && ld_miss) |-> wr_inv);
  assert_alu_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!kind && src_inv == 2'b00) |-> !wr_inv);
endmodule

// File: rtl/rah_rf_cell.sv
// One register: data, invalid flag and shadow copy.
module rah_rf_cell #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ckpt,
  input  logic          rstr,
  input  logic          wr_hit,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_inv,
  output logic [DW-1:0] data_q,
  output logic          inv_q
);
  logic [DW-1:0] shadow_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q   <= '0;
      inv_q    <= 1'b0;
      shadow_q <= '0;
    end else begin
      if (ckpt) shadow_q <= data_q;
      if (rstr) begin
        data_q <= shadow_q;
        inv_q  <= 1'b0;
      end else if (wr_hit) begin
        data_q <= wr_data;
        inv_q  <= wr_inv;
      end
    end
  end

  assert_shadow_snapshot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ckpt |=> (shadow_q == $past(data_q)));
  assert_restore_reload_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rstr |=> (data_q == $past(shadow_q)));
endmodule

// File: rtl/rah_rd_port.sv
// Read mux with write-first bypass.
module rah_rd_port #(
  parameter int NREGS = 32,
  parameter int DW    = 32,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [AW-1:0]              addr,
  input  logic [NREGS-1:0][DW-1:0]   regs,
  input  logic [NREGS-1:0]           invs,
  input  logic                       byp_en,
  input  logic [AW-1:0]              byp_addr,
  input  logic [DW-1:0]              byp_data,
  input  logic                       byp_inv,
  output logic [DW-1:0]              data,
  output logic                       inv
);
  always_comb begin
    if (byp_en && (byp_addr == addr)) begin
      data = byp_data;
      inv  = byp_inv;
    end else begin
      data = regs[addr];
      inv  = invs[addr];
    end
  end

  assert_zero_reg_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == '0) |-> (data == '0 && !inv));
  assert_bypass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (byp_en && byp_addr == addr) |-> (data == byp_data && inv == byp_inv));
endmodule

// File: rtl/rah_ckpt_regfile.sv
module rah_ckpt_regfile #(
  parameter int NREGS = 32,
  parameter int DW    = 32,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          spec_mode,
  input  logic          ckpt_req,
  input  logic          rstr_req,
  input  logic [AW-1:0] rd_addr_a,
  output logic [DW-1:0] rd_data_a,
  output logic          rd_inv_a,
  input  logic [AW-1:0] rd_addr_b,
  output logic [DW-1:0] rd_data_b,
  output logic          rd_inv_b,
  input  logic          wr_en,
  input  logic          wr_kind,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [1:0]    wr_src_inv,
  input  logic          wr_ld_miss,
  input  logic          wr_ld_word_inv
);
  logic                     wr_fire;
  logic                     wr_inv;
  logic [NREGS-1:0][DW-1:0] reg_vec;
  logic [NREGS-1:0]         inv_vec;

  // A restore discards a write in the same cycle; register 0 never takes one.
  assign wr_fire = wr_en && !rstr_req && (wr_addr != '0);

  rah_inv_eval u_inv (
    .clk         (clk),
    .rst_n       (rst_n),
    .spec_mode   (spec_mode),
    .kind        (wr_kind),
    .src_inv     (wr_src_inv),
    .ld_miss     (wr_ld_miss),
    .ld_word_inv (wr_ld_word_inv),
    .wr_inv      (wr_inv)
  );

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    if (g == 0) begin : g_zero
      assign reg_vec[g] = '0;
      assign inv_vec[g] = 1'b0;
    end else begin : g_live
      logic          hit;
      logic [DW-1:0] q;
      logic          qi;
      assign hit = wr_fire && (wr_addr == AW'(g));
      rah_rf_cell #(.DW(DW)) u_cell (
        .clk     (clk),
        .rst_n   (rst_n),
        .ckpt    (ckpt_req),
        .rstr    (rstr_req),
        .wr_hit  (hit),
        .wr_data (wr_data),
        .wr_inv  (wr_inv),
        .data_q  (q),
        .inv_q   (qi)
      );
      assign reg_vec[g] = q;
      assign inv_vec[g] = qi;
    end
  end

  rah_rd_port #(.NREGS(NREGS), .DW(DW)) u_rd_a (
    .clk (clk), .rst_n (rst_n), .addr (rd_addr_a),
    .regs (reg_vec), .invs (inv_vec),
    .byp_en (wr_fire), .byp_addr (wr_addr), .byp_data (wr_data), .byp_inv (wr_inv),
    .data (rd_data_a), .inv (rd_inv_a)
  );

  rah_rd_port #(.NREGS(NREGS), .DW(DW)) u_rd_b (
    .clk (clk), .rst_n (rst_n), .addr (rd_addr_b),
    .regs (reg_vec), .invs (inv_vec),
    .byp_en (wr_fire), .byp_addr (wr_addr), .byp_data (wr_data), .byp_inv (wr_inv),
    .data (rd_data_b), .inv (rd_inv_b)
  );

  assert_restore_all_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rstr_req |=> (inv_vec == '0));
  assert_outside_no_new_inv_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!spec_mode && !rstr_req && wr_en && wr_addr != '0) |=> !inv_vec[$past(wr_addr)]);
endmodule

// File: tb/sim_rah_ckpt_regfile.sv
`timescale 1ns/1ps
module sim_rah_ckpt_regfile;
  localparam int NREGS = 32;
  localparam int DW    = 32;
  localparam int AW    = $clog2(NREGS);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spec_mode = 0, ckpt_req = 0, rstr_req = 0;
  logic [AW-1:0] rd_addr_a = '0, rd_addr_b = '0, wr_addr = '0;
  logic [DW-1:0] rd_data_a, rd_data_b, wr_data = '0;
  logic rd_inv_a, rd_inv_b;
  logic wr_en = 0, wr_kind = 0, wr_ld_miss = 0, wr_ld_word_inv = 0;
  logic [1:0] wr_src_inv = '0;

  int checks = 0;
  int errors = 0;

  logic [DW-1:0] m_rf [NREGS];
  logic [DW-1:0] m_bk [NREGS];
  bit            m_inv[NREGS];

  always #2 clk = ~clk;

  rah_ckpt_regfile #(.NREGS(NREGS), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .spec_mode(spec_mode), .ckpt_req(ckpt_req), .rstr_req(rstr_req),
    .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a), .rd_inv_a(rd_inv_a),
    .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b), .rd_inv_b(rd_inv_b),
    .wr_en(wr_en), .wr_kind(wr_kind), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_src_inv(wr_src_inv), .wr_ld_miss(wr_ld_miss), .wr_ld_word_inv(wr_ld_word_inv)
  );

  function automatic bit exp_flag();
    if (!spec_mode) return 1'b0;
    if (wr_kind) return wr_src_inv[0] | wr_ld_miss | wr_ld_word_inv;
    return wr_src_inv[0] | wr_src_inv[1];
  endfunction

  function automatic bit write_lands();
    return wr_en && !rstr_req && (wr_addr != '0);
  endfunction

  task automatic chk(string tag, string port, logic [DW-1:0] gd, logic [DW-1:0] ed,
                     logic gi, logic ei);
    checks++;
    if (gd !== ed || gi !== ei) begin
      errors++;
      $display("FAIL %s port %s: got data=%h inv=%b expected data=%h inv=%b",
               tag, port, gd, gi, ed, ei);
    end
  endtask

  task automatic cyc(string tag);
    logic [DW-1:0] ea, eb;
    bit ia, ib;
    logic [DW-1:0] old_rf [NREGS];
    @(negedge clk);
    ea = m_rf[rd_addr_a]; ia = m_inv[rd_addr_a];
    eb = m_rf[rd_addr_b]; ib = m_inv[rd_addr_b];
    if (write_lands() && wr_addr == rd_addr_a) begin ea = wr_data; ia = exp_flag(); end
    if (write_lands() && wr_addr == rd_addr_b) begin eb = wr_data; ib = exp_flag(); end
    chk(tag, "A", rd_data_a, ea, rd_inv_a, ia);
    chk(tag, "B", rd_data_b, eb, rd_inv_b, ib);
    @(posedge clk);
    for (int i = 0; i < NREGS; i++) old_rf[i] = m_rf[i];
    if (rstr_req) begin
      for (int i = 0; i < NREGS; i++) begin m_rf[i] = m_bk[i]; m_inv[i] = 0; end
    end else if (write_lands()) begin
      m_rf[wr_addr] = wr_data; m_inv[wr_addr] = exp_flag();
    end
    if (ckpt_req) for (int i = 0; i < NREGS; i++) m_bk[i] = old_rf[i];
    #1;
  endtask

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d, logic k, logic [1:0] s,
                    logic miss, logic winv);
    wr_en = 1; wr_addr = a; wr_data = d; wr_kind = k; wr_src_inv = s;
    wr_ld_miss = miss; wr_ld_word_inv = winv;
  endtask

  task automatic idle();
    wr_en = 0; ckpt_req = 0; rstr_req = 0; wr_src_inv = 0; wr_ld_miss = 0; wr_ld_word_inv = 0;
  endtask

  task automatic sweep(string tag);
    idle();
    for (int i = 0; i < NREGS; i += 2) begin
      rd_addr_a = AW'(i); rd_addr_b = AW'(i + 1); cyc(tag);
    end
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: got run still active, expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < NREGS; i++) begin m_rf[i] = '0; m_bk[i] = '0; m_inv[i] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    sweep("R1");

    // R2: plain writes, then reads
    wr(5, 32'hA5A5_0005, 0, 2'b00, 0, 0); rd_addr_a = 6; rd_addr_b = 4; cyc("R2");
    wr(6, 32'h1234_0006, 1, 2'b00, 0, 0); rd_addr_a = 5; cyc("R2");
    idle(); rd_addr_a = 5; rd_addr_b = 6; cyc("R2");

    // R3: read of the register being written
    wr(7, 32'hDEAD_0007, 0, 2'b00, 0, 0); rd_addr_a = 7; rd_addr_b = 7; cyc("R3");
    idle(); cyc("R3");

    // R4: register 0
    wr(0, 32'hFFFF_FFFF, 0, 2'b00, 0, 0); rd_addr_a = 0; rd_addr_b = 0; cyc("R4");
    idle(); cyc("R4");

    // R10: checkpoint with a write to 5 in the same cycle
    ckpt_req = 1; wr(5, 32'hBEEF_0005, 0, 2'b00, 0, 0); rd_addr_a = 5; cyc("R10");
    idle(); spec_mode = 1; cyc("R10");

    // R5 / R6: register-to-register in speculative mode
    wr(3, 32'h0000_0333, 0, 2'b01, 0, 0); rd_addr_a = 3; rd_addr_b = 4; cyc("R5");
    wr(4, 32'h0000_0444, 0, 2'b10, 0, 0); cyc("R5");
    idle(); cyc("R5");
    wr(3, 32'h0000_0303, 0, 2'b00, 0, 0); cyc("R6");
    idle(); cyc("R6");

    // R7 / R8: loads
    wr(8,  32'h88, 1, 2'b01, 0, 0); rd_addr_a = 8; rd_addr_b = 9; cyc("R7");
    wr(9,  32'h99, 1, 2'b00, 1, 0); cyc("R7");
    wr(10, 32'hAA, 1, 2'b00, 0, 1); rd_addr_b = 10; cyc("R7");
    wr(11, 32'hBB, 1, 2'b10, 0, 0); rd_addr_a = 11; cyc("R8");
    idle(); rd_addr_a = 8; rd_addr_b = 9; cyc("R7");
    wr(8,  32'h8080, 1, 2'b00, 0, 0); cyc("R8");
    idle(); cyc("R8");

    // R11: restore with a colliding write
    rstr_req = 1; wr(3, 32'h5555_5555, 0, 2'b11, 0, 0); rd_addr_a = 3; rd_addr_b = 5; cyc("R11");
    spec_mode = 0;
    sweep("R11");

    // R9: outside speculative mode, flag inputs ignored
    wr(12, 32'hC0C0, 1, 2'b11, 1, 1); rd_addr_a = 12; cyc("R9");
    wr(13, 32'hD0D0, 0, 2'b11, 0, 0); rd_addr_b = 13; cyc("R9");
    idle(); cyc("R9");

    // R12: checkpoint and restore together
    ckpt_req = 1; cyc("R12");
    wr(14, 32'hE0E0, 0, 2'b00, 0, 0); cyc("R12");
    wr(15, 32'hF0F0, 0, 2'b00, 0, 0); cyc("R12");
    idle(); ckpt_req = 1; rstr_req = 1; rd_addr_a = 14; rd_addr_b = 15; cyc("R12");
    sweep("R12");
    rstr_req = 1; cyc("R12");
    sweep("R12");

    // Random mix of every function
    for (int n = 0; n < 3000; n++) begin
      spec_mode = ($urandom_range(0, 3) != 0);
      ckpt_req = ($urandom_range(0, 15) == 0);
      rstr_req = ($urandom_range(0, 15) == 0);
      wr_en = ($urandom_range(0, 3) != 0);
      wr_kind = 1'($urandom_range(0, 1));
      wr_addr = AW'($urandom_range(0, NREGS - 1));
      wr_data = $urandom;
      wr_src_inv = 2'($urandom_range(0, 3));
      wr_ld_miss = ($urandom_range(0, 3) == 0);
      wr_ld_word_inv = ($urandom_range(0, 3) == 0);
      rd_addr_a = ($urandom_range(0, 2) == 0) ? wr_addr : AW'($urandom_range(0, NREGS - 1));
      rd_addr_b = AW'($urandom_range(0, NREGS - 1));
      cyc("R2");
    end
    sweep("R2");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule